// File: doc/BRIEF.md
# I2C Slave Protocol Engine

This block is the serial front end of a small converter peripheral. It watches the two bus lines with the system clock and finds START, repeated START and STOP conditions. It checks the slave address bit by bit. It pulls SDA low through an open-drain enable to acknowledge, and it hands every received byte to a downstream register block with a one-cycle strobe. In a read transfer it shifts out a 16-bit word that the register block supplies.

The upper six address bits are a parameter and the lowest address bit follows a strap input. After a failed address compare or a STOP, the engine stays deaf to SCL until the next START. Written bytes are numbered 0 and 1 within each two-byte pair. If a transfer ends after the first byte of a pair has been delivered, the engine raises an abort pulse so the register block can drop that half-written pair.

The bus lines pass through a synchroniser, so the system clock must run at least eight times faster than SCL.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset the engine is idle with `sdaOe` low and no `byteValid` or `abortPulse` pulse, and it treats SDA falling while SCL is high as START and SDA rising while SCL is high as STOP.
- R2: After a START the engine takes seven address bits MSB first and then one direction bit (0 = write, 1 = read). When the seven bits equal `{ADDR_HI, addrStrap}` it drives `sdaOe` high for the whole ninth clock.
- R3: On the first address bit that differs from its own address the engine gives no acknowledge. It then ignores all SCL activity, with no acknowledge and no strobe, until the next START.
- R4: `addrStrap` is the lowest address bit. With the strap high, address `{ADDR_HI,1}` is acknowledged and `{ADDR_HI,0}` is not.
- R5: The all-zero general call address is never acknowledged.
- R6: In a write, each data byte is acknowledged. `byteValid` pulses for one cycle after the SCL fall that ends that acknowledge, with the byte on `rxByte` (first bit received in bit 7). `byteIdx` is 0 for the first byte of a pair and 1 for the second.
- R7: Writes may continue past two bytes in one transfer. `byteIdx` keeps alternating 0,1,0,1, and it restarts at 0 after any START or STOP.
- R8: A repeated START without a STOP begins a new address phase, including a change from write to read.
- R9: In a read, `rdWord[15:8]` is driven MSB first starting right after the address acknowledge. If the master acknowledges (SDA low in the ninth clock), `rdWord[7:0]` follows. After a master not-acknowledge, SDA stays released for the rest of the transfer.
- R10: A STOP at any bit position returns the engine to idle. `abortPulse` pulses once when a START or STOP arrives after the first byte of a write pair was delivered but before the second byte's strobe.
- R11: A STOP that occurs in the same SCL high period as the preceding START is ignored, and the transfer begun by that START continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as sensed |
| sdaIn | input | 1 | Bus data line as sensed |
| addrStrap | input | 1 | Strap giving the lowest address bit |
| rdWord | input | 16 | Word returned in a read, upper byte first |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| rxByte | output | 8 | Last received byte, valid with byteValid |
| byteValid | output | 1 | One-cycle strobe for a received write byte |
| byteIdx | output | 1 | Position of the byte within its pair |
| abortPulse | output | 1 | One-cycle pulse when a write pair is cut short |

## Verification
The bench sweeps all 128 seven-bit addresses and follows each one with a data byte. A compare that looked only at some bits, or that kept listening after a mismatch, would acknowledge a wrong address or that follow-up byte. Long back-to-back writes and repeated STARTs catch a pair index that fails to alternate or fails to restart. Several read words catch an off-by-one between the upper and lower byte at the master acknowledge. A STOP placed inside the START's own high period, STOPs after one byte and after two bytes, and a repeated START in the middle of a byte check the abort pulse: a design that honoured the early STOP, or pulsed after a complete pair, would show a wrong acknowledge or abort count.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  // what the datapath does with the SDA pull-down this cycle
  typedef enum logic [2:0] {
    OE_KEEP,
    OE_REL,
    OE_ACK,
    OE_LOAD,
    OE_TXCUR,
    OE_TXNEXT
  } oe_op_e;

  typedef struct packed {
    logic   clrCnt;
    logic   incCnt;
    logic   shiftRx;
    logic   loadTx;
    logic   shiftTx;
    oe_op_e oeOp;
  } ctrl_strobe_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } bus_event_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eng_state_e;

endpackage

// File: rtl/i2c_slave_dpath.sv
module i2c_slave_dpath
  import i2c_slave_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011010,
  localparam int CNT_W  = $clog2(BYTE_W + 1),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  input  logic [WORD_W-1:0] rdWord,
  input  ctrl_strobe_t      c,
  output bus_event_t        ev,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              addrBitOk,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclD, sdaD, sclS, sdaS;
  logic [ADDR_W-1:0] addrLeft;
  logic [WORD_W-1:0] txShift;

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  // both lines idle high, so the synchroniser resets high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign ev.sclRise   = sclS & ~sclD;
  assign ev.sclFall   = ~sclS & sclD;
  assign ev.startSeen = sclS & sclD & sdaD & ~sdaS;
  assign ev.stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign ev.sdaBit    = sdaS;

  // address shadow walks in step with the received bits
  assign addrBitOk = (sdaS == addrLeft[ADDR_W-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxByte   <= '0;
      addrLeft <= '0;
      txShift  <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (c.clrCnt)      bitCnt <= '0;
      else if (c.incCnt) bitCnt <= bitCnt + 1'b1;

      if (c.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaS};

      if (c.clrCnt)       addrLeft <= {ADDR_HI, addrStrap};
      else if (c.shiftRx) addrLeft <= addrLeft << 1;

      if (c.loadTx)       txShift <= rdWord;
      else if (c.shiftTx) txShift <= txShift << 1;

      case (c.oeOp)
        OE_REL:    sdaOe <= 1'b0;
        OE_ACK:    sdaOe <= 1'b1;
        OE_LOAD:   sdaOe <= ~rdWord[WORD_W-1];
        OE_TXCUR:  sdaOe <= ~txShift[WORD_W-1];
        OE_TXNEXT: sdaOe <= ~txShift[WORD_W-2];
        default:   sdaOe <= sdaOe;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bus_event_t        ev,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              addrBitOk,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrl_strobe_t      c,
  output logic              byteValid,
  output logic              byteIdx,
  output logic              abortPulse
);

  eng_state_e state, nState;
  logic isRd, nIsRd, wrIdx, nWrIdx, secondByte, nSecond;
  logic masterAck, nMAck, startHigh, wrOpen;
  logic bvN, abN, idxN;

  assign wrOpen = (state == ST_WDATA || state == ST_WACK) && wrIdx;

  always_comb begin
    nState  = state;
    c       = '0;
    c.oeOp  = OE_KEEP;
    nIsRd   = isRd;
    nWrIdx  = wrIdx;
    nSecond = secondByte;
    nMAck   = masterAck;
    bvN     = 1'b0;
    abN     = 1'b0;
    idxN    = byteIdx;
    if (ev.startSeen) begin
      nState   = ST_ADDR;
      c.clrCnt = 1'b1;
      c.oeOp   = OE_REL;
      abN      = wrOpen;
      nWrIdx   = 1'b0;
    end else if (ev.stopSeen && !startHigh) begin
      nState = ST_IDLE;
      c.oeOp = OE_REL;
      abN    = wrOpen;
      nWrIdx = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            if (bitCnt < CNT_W'(ADDR_W) && !addrBitOk) nState = ST_IDLE;
            else begin
              c.shiftRx = 1'b1;
              c.incCnt  = 1'b1;
            end
          end else if (ev.sclFall && bitCnt == CNT_W'(BYTE_W)) begin
            if (rxByte[BYTE_W-1:1] == '0) nState = ST_IDLE;
            else begin
              nState = ST_AACK;
              c.oeOp = OE_ACK;
              nIsRd  = rxByte[0];
            end
          end
        end
        ST_AACK: if (ev.sclFall) begin
          c.clrCnt = 1'b1;
          if (isRd) begin
            nState   = ST_RDATA;
            c.loadTx = 1'b1;
            c.oeOp   = OE_LOAD;
            nSecond  = 1'b0;
          end else begin
            nState = ST_WDATA;
            c.oeOp = OE_REL;
          end
        end
        ST_WDATA: begin
          if (ev.sclRise) begin
            c.shiftRx = 1'b1;
            c.incCnt  = 1'b1;
          end else if (ev.sclFall && bitCnt == CNT_W'(BYTE_W)) begin
            nState = ST_WACK;
            c.oeOp = OE_ACK;
          end
        end
        ST_WACK: if (ev.sclFall) begin
          bvN      = 1'b1;
          idxN     = wrIdx;
          nWrIdx   = ~wrIdx;
          nState   = ST_WDATA;
          c.clrCnt = 1'b1;
          c.oeOp   = OE_REL;
        end
        ST_RDATA: if (ev.sclFall) begin
          c.shiftTx = 1'b1;
          if (bitCnt == CNT_W'(BYTE_W - 1)) begin
            nState = ST_RACK;
            c.oeOp = OE_REL;
          end else begin
            c.incCnt = 1'b1;
            c.oeOp   = OE_TXNEXT;
          end
        end
        ST_RACK: begin
          if (ev.sclRise) nMAck = ~ev.sdaBit;
          else if (ev.sclFall) begin
            if (masterAck && !secondByte) begin
              nState   = ST_RDATA;
              nSecond  = 1'b1;
              c.clrCnt = 1'b1;
              c.oeOp   = OE_TXCUR;
            end else begin
              nState = ST_IDLE;
              c.oeOp = OE_REL;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      isRd       <= 1'b0;
      wrIdx      <= 1'b0;
      secondByte <= 1'b0;
      masterAck  <= 1'b0;
      startHigh  <= 1'b0;
      byteValid  <= 1'b0;
      byteIdx    <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      state      <= nState;
      isRd       <= nIsRd;
      wrIdx      <= nWrIdx;
      secondByte <= nSecond;
      masterAck  <= nMAck;
      byteValid  <= bvN;
      byteIdx    <= idxN;
      abortPulse <= abN;
      if (ev.startSeen)    startHigh <= 1'b1;
      else if (ev.sclFall) startHigh <= 1'b0;
    end
  end

  a_r6_strobe_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(state) == ST_WACK);

  a_r10_abort_needs_half_pair: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(wrIdx));

  a_r11_early_stop_masked: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && startHigh && ev.stopSeen && !ev.startSeen) |=> state == ST_ADDR);

  a_r3_idle_deaf: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !ev.startSeen) |=> state == ST_IDLE);

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_slave_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011010,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  input  logic [WORD_W-1:0] rdWord,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteValid,
  output logic              byteIdx,
  output logic              abortPulse
);

  ctrl_strobe_t     strobes;
  bus_event_t       events;
  logic [CNT_W-1:0] bitCnt;
  logic             addrBitOk;

  i2c_slave_dpath #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI)
  ) uDpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .rdWord(rdWord), .c(strobes), .ev(events), .bitCnt(bitCnt),
    .addrBitOk(addrBitOk), .rxByte(rxByte), .sdaOe(sdaOe)
  );

  i2c_slave_ctrl #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ev(events), .bitCnt(bitCnt), .addrBitOk(addrBitOk),
    .rxByte(rxByte), .c(strobes), .byteValid(byteValid), .byteIdx(byteIdx),
    .abortPulse(abortPulse)
  );

  // the pull-down moves only while the bus clock is low
  a_r1_oe_moves_in_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

endmodule

// File: tb/tb_i2c_slave_engine.sv
module tb_i2c_slave_engine;

  localparam logic [5:0] HI = 6'b011010;
  localparam logic [6:0] ADDR0 = {HI, 1'b0};
  localparam logic [6:0] ADDR1 = {HI, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic strap = 1'b0;
  logic [15:0] rdWord = 16'h0000;
  logic sdaOe, byteValid, byteIdx, abortPulse;
  logic [7:0] rxByte;
  wire sdaBus = sdaM & ~sdaOe;

  int checks = 0, errors = 0, vCnt = 0, abCnt = 0;
  logic [7:0] lastByte;
  logic lastIdx;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_slave_engine #(.ADDR_HI(HI)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrStrap(strap),
    .rdWord(rdWord), .sdaOe(sdaOe), .rxByte(rxByte), .byteValid(byteValid),
    .byteIdx(byteIdx), .abortPulse(abortPulse)
  );

  always @(negedge clk) if (rstN) begin
    if (byteValid) begin
      vCnt++;
      lastByte = rxByte;
      lastIdx = byteIdx;
    end
    if (abortPulse) abCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic s);
    sdaM = b; tick(6);
    sclM = 1'b1; tick(4);
    s = sdaBus; tick(4);
    sclM = 1'b0; tick(3);
  endtask

  task automatic busStart;
    sdaM = 1'b1; tick(4);
    sclM = 1'b1; tick(6);
    sdaM = 1'b0; tick(6);
    sclM = 1'b0; tick(4);
  endtask

  task automatic busStop;
    sdaM = 1'b0; tick(4);
    sclM = 1'b1; tick(6);
    sdaM = 1'b1; tick(8);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], s);
    sendBit(1'b1, s);
    ack = ~s;
    tick(6);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sendBit(1'b1, s);
      d[i] = s;
    end
    sendBit(~mAck, s);
    tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d1, d2;
    int v0, a0;
    tick(5);
    // R1: reset state
    check(sdaOe == 1'b0, "R1 oe after reset", sdaOe, 0);
    check(byteValid == 1'b0 && abortPulse == 1'b0, "R1 strobes after reset",
          {byteValid, abortPulse}, 0);
    rstN = 1'b1;
    tick(5);

    // R2/R3/R5: full address sweep, strap low, each followed by one data byte
    for (int a = 0; a < 128; a++) begin
      logic expAck;
      expAck = (7'(a) == ADDR0) && (a != 0);
      v0 = vCnt;
      busStart;
      writeByte({7'(a), 1'b0}, ack);
      if (a == 0) check(ack == 1'b0, "R5 general call", ack, 0);
      else if (expAck) check(ack == 1'b1, "R2 own address ack", ack, 1);
      else check(ack == 1'b0, "R3 foreign address", ack, 0);
      writeByte(8'h5A, ack2);
      check(ack2 == expAck, "R3 byte after address", ack2, expAck);
      busStop;
      check(vCnt == v0 + (expAck ? 1 : 0), "R3 strobe count", vCnt - v0, expAck ? 1 : 0);
    end

    // R4: strap selects the low address bit
    strap = 1'b1;
    busStart; writeByte({ADDR1, 1'b0}, ack); busStop;
    check(ack == 1'b1, "R4 strap high own address", ack, 1);
    busStart; writeByte({ADDR0, 1'b0}, ack); busStop;
    check(ack == 1'b0, "R4 strap high old address", ack, 0);
    strap = 1'b0;

    // R6/R7: long write with values computed per byte
    busStart; writeByte({ADDR0, 1'b0}, ack);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] val;
      val = 8'((k * 37 + 5) ^ (k * 11));
      v0 = vCnt;
      writeByte(val, ack);
      check(ack == 1'b1, "R6 data ack", ack, 1);
      check(vCnt == v0 + 1 && lastByte == val, "R6 byte value", lastByte, val);
      check(lastIdx == 1'(k % 2), "R7 pair index", lastIdx, k % 2);
    end
    busStop;

    // R10: STOP after a complete pair gives no abort
    a0 = abCnt;
    busStart; writeByte({ADDR0, 1'b0}, ack); writeByte(8'h11, ack); writeByte(8'h22, ack); busStop;
    check(abCnt == a0, "R10 no abort after full pair", abCnt - a0, 0);
    // R10: STOP after one byte aborts
    busStart; writeByte({ADDR0, 1'b0}, ack); writeByte(8'h33, ack); busStop;
    check(abCnt == a0 + 1, "R10 abort on stop", abCnt - a0, 1);
    // R10: STOP honoured, later bytes ignored
    v0 = vCnt;
    writeByte(8'h44, ack);
    check(ack == 1'b0 && vCnt == v0, "R10 deaf after stop", {ack, 8'(vCnt - v0)}, 0);

    // R8/R10: repeated START mid-byte aborts, index restarts at 0
    busStart; writeByte({ADDR0, 1'b0}, ack); writeByte(8'h55, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1, ack2);
    busStart;
    check(abCnt == a0 + 2, "R10 abort on repeated start", abCnt - a0, 2);
    writeByte({ADDR0, 1'b0}, ack);
    check(ack == 1'b1, "R8 address after repeated start", ack, 1);
    writeByte(8'h66, ack);
    check(lastIdx == 1'b0 && lastByte == 8'h66, "R7 index restart", {lastIdx, lastByte}, 8'h66);
    busStop;

    // R9: reads of several words
    for (int w = 0; w < 4; w++) begin
      logic [15:0] word;
      word = 16'((w * 16'h4D35) ^ 16'hA5C3);
      rdWord = word;
      busStart; writeByte({ADDR0, 1'b1}, ack);
      check(ack == 1'b1, "R9 read address ack", ack, 1);
      readByte(1'b1, d1);
      readByte(1'b0, d2);
      busStop;
      check(d1 == word[15:8], "R9 upper byte", d1, word[15:8]);
      check(d2 == word[7:0], "R9 lower byte", d2, word[7:0]);
      check(sdaOe == 1'b0, "R9 released after nack", sdaOe, 0);
    end

    // R8/R9: write then repeated START into read; NACK after first byte
    rdWord = 16'h0F3C;
    busStart; writeByte({ADDR0, 1'b0}, ack); writeByte(8'h77, ack);
    busStart; writeByte({ADDR0, 1'b1}, ack);
    check(ack == 1'b1, "R8 switch to read", ack, 1);
    readByte(1'b0, d1);
    check(d1 == 8'h0F, "R9 upper after switch", d1, 8'h0F);
    readByte(1'b0, d2);
    check(d2 == 8'hFF, "R9 released after first nack", d2, 8'hFF);
    busStop;

    // R11: STOP inside the START's own high period is ignored
    sdaM = 1'b1; tick(4);
    sclM = 1'b1; tick(6);
    sdaM = 1'b0; tick(6);
    sdaM = 1'b1; tick(6);
    sclM = 1'b0; tick(4);
    v0 = vCnt;
    writeByte({ADDR0, 1'b0}, ack);
    check(ack == 1'b1, "R11 early stop ignored", ack, 1);
    writeByte(8'h99, ack);
    check(vCnt == v0 + 1 && lastByte == 8'h99, "R11 transfer continues", lastByte, 8'h99);
    busStop;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule